// File: doc/BRIEF.md
# Deblocking Edge Decision Unit

This unit inspects the pixels on both sides of one block edge in a video decoder's deblocking stage and decides what filtering that edge should receive. It takes eight pixels on each side of the edge, three per-edge thresholds given on an 8-bit scale, a filter-width mode and a bit-depth select. It returns four registered flags: filter enable, high edge variance, inner flat and outer flat.

The thresholds are rescaled to the selected bit depth before any comparison. The flags are nested. Inner flat can only be set where filtering is enabled, and outer flat only where inner flat is set. The width mode limits which flatness flags may be set at all. The filter datapath that follows reads these flags, together with a valid strobe, one clock after it presents the pixels.

Top module: `dbk_edge_judge`

## Requirements
- R1: The edge, interior and variance thresholds are shifted left before use. The shift is 2 when `depth_sel`=0 (10-bit) and 4 when `depth_sel`=1 (12-bit). The flatness threshold is 4 in 10-bit mode and 16 in 12-bit mode.
- R2: `flt_en` requires each of the six neighbour differences |p3-p2|, |p2-p1|, |p1-p0|, |q0-q1|, |q1-q2| and |q2-q3| to be at most the scaled interior threshold.
- R3: `flt_en` also requires 2*|p0-q0| + (|p1-q1| >> 1) to be at most the scaled edge threshold.
- R4: `hev` is 1 exactly when max(|p1-p0|, |q1-q0|) is strictly greater than the scaled variance threshold. It is not gated by `flt_en`.
- R5: `flat_in` is 1 only when `flt_en` is 1 and each of |p1-p0|, |p2-p0|, |p3-p0|, |q1-q0|, |q2-q0| and |q3-q0| is at most the flatness threshold.
- R6: `flat_out` is 1 only when `flat_in` is 1, the mode is width 16, and each of |p4..p7 - p0| and |q4..q7 - q0| is at most the flatness threshold.
- R7: `width_sel` encodes 2'b00 = width 4, 2'b01 = width 8 and 2'b10 = width 16. 2'b11 behaves as width 4. Width 4 forces `flat_in` and `flat_out` low. Width 8 forces `flat_out` low.
- R8: The flags and `out_valid` appear on the first rising edge after `in_valid`. `out_valid` is low in the cycle after a cycle without `in_valid`. The flags keep their values while `in_valid` is low. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an edge to judge |
| p_pix | input | 8x12 | Pixels on the p side; element k is pk, p0 nearest the edge |
| q_pix | input | 8x12 | Pixels on the q side; element k is qk, q0 nearest the edge |
| thr_edge | input | 8 | Edge threshold, 8-bit scale |
| thr_inner | input | 8 | Interior threshold, 8-bit scale |
| thr_hev | input | 8 | Variance threshold, 8-bit scale |
| width_sel | input | 2 | Filter width mode |
| depth_sel | input | 1 | 0 = 10-bit, 1 = 12-bit |
| out_valid | output | 1 | Flags below are fresh |
| flt_en | output | 1 | Filter enable |
| hev | output | 1 | High edge variance |
| flat_in | output | 1 | Inner flatness |
| flat_out | output | 1 | Outer flatness |

## Verification
Every flag has exactly one register between the inputs and the outputs. A vector driven on a falling edge is therefore due at the ports after the next rising edge. The bench reads it on the falling edge that follows, so it never samples at the edge where the outputs change. The hold case drives new pixels with `in_valid` low for one full cycle. It then checks, on the following falling edge, that the flags are unchanged and `out_valid` is low.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  typedef enum logic [1:0] {
    WID_4   = 2'b00,
    WID_8   = 2'b01,
    WID_16  = 2'b10,
    WID_RSV = 2'b11
  } dbk_width_e;

  typedef struct packed {
    logic en;
    logic hev;
    logic fin;
    logic fout;
  } dbk_flags_t;
endpackage

// File: rtl/dbk_thr_scale.sv
module dbk_thr_scale #(
  parameter int THR_W    = 8,
  parameter int DEPTH_LO = 10,
  parameter int DEPTH_HI = 12,
  parameter int SCL_W    = THR_W + DEPTH_HI - 8,
  parameter int DIFF_W   = 13
) (
  input  logic              depth_sel,
  input  logic [THR_W-1:0]  thr_edge,
  input  logic [THR_W-1:0]  thr_inner,
  input  logic [THR_W-1:0]  thr_hev,
  output logic [SCL_W-1:0]  e_scl,
  output logic [SCL_W-1:0]  i_scl,
  output logic [SCL_W-1:0]  h_scl,
  output logic [DIFF_W-1:0] flat_thr
);
  localparam int SH_LO = DEPTH_LO - 8;
  localparam int SH_HI = DEPTH_HI - 8;

  logic [3:0] sh;

  always_comb begin
    sh       = depth_sel ? 4'(SH_HI) : 4'(SH_LO);
    e_scl    = SCL_W'(thr_edge)  << sh;
    i_scl    = SCL_W'(thr_inner) << sh;
    h_scl    = SCL_W'(thr_hev)   << sh;
    flat_thr = DIFF_W'(1) << sh;
  end
endmodule

// File: rtl/dbk_mask_eval.sv
module dbk_mask_eval #(
  parameter int PIX_W  = 12,
  parameter int SCL_W  = 12,
  parameter int DIFF_W = PIX_W + 1
) (
  input  logic [3:0][PIX_W-1:0] p_near,
  input  logic [3:0][PIX_W-1:0] q_near,
  input  logic [SCL_W-1:0]      e_scl,
  input  logic [SCL_W-1:0]      i_scl,
  input  logic [SCL_W-1:0]      h_scl,
  output logic                  en,
  output logic                  hev
);
  localparam int MET_W = DIFF_W + 2;
  localparam int CMP_W = (MET_W > SCL_W) ? MET_W : SCL_W;

  function automatic logic [DIFF_W-1:0] adiff(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
    return (a >= b) ? DIFF_W'(a - b) : DIFF_W'(b - a);
  endfunction

  logic [2:0] p_ok, q_ok;
  logic [DIFF_W-1:0] d_p10, d_q10, d_pq0, d_pq1;
  logic [DIFF_W-1:0] d_var;
  logic [CMP_W-1:0]  edge_met;

  for (genvar g = 0; g < 3; g++) begin : g_nbr
    assign p_ok[g] = CMP_W'(adiff(p_near[g+1], p_near[g])) <= CMP_W'(i_scl);
    assign q_ok[g] = CMP_W'(adiff(q_near[g+1], q_near[g])) <= CMP_W'(i_scl);
  end

  always_comb begin
    d_p10    = adiff(p_near[1], p_near[0]);
    d_q10    = adiff(q_near[1], q_near[0]);
    d_pq0    = adiff(p_near[0], q_near[0]);
    d_pq1    = adiff(p_near[1], q_near[1]);
    d_var    = (d_p10 > d_q10) ? d_p10 : d_q10;
    edge_met = (CMP_W'(d_pq0) << 1) + CMP_W'(d_pq1 >> 1);
    en       = (&p_ok) && (&q_ok) && (edge_met <= CMP_W'(e_scl));
    hev      = CMP_W'(d_var) > CMP_W'(h_scl);
  end
endmodule

// File: rtl/dbk_flat_eval.sv
module dbk_flat_eval #(
  parameter int PIX_W  = 12,
  parameter int NUM    = 3,
  parameter int DIFF_W = PIX_W + 1
) (
  input  logic [NUM-1:0][PIX_W-1:0] pix,
  input  logic [PIX_W-1:0]          anchor,
  input  logic [DIFF_W-1:0]         flat_thr,
  output logic                      all_flat
);
  logic [NUM-1:0] ok;

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    logic [DIFF_W-1:0] d;
    assign d     = (pix[g] >= anchor) ? DIFF_W'(pix[g] - anchor)
                                      : DIFF_W'(anchor - pix[g]);
    assign ok[g] = d <= flat_thr;
  end

  assign all_flat = &ok;
endmodule

// File: rtl/dbk_edge_judge.sv
module dbk_edge_judge #(
  parameter int PIX_W    = 12,
  parameter int THR_W    = 8,
  parameter int DEPTH_LO = 10,
  parameter int DEPTH_HI = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0][PIX_W-1:0] p_pix,
  input  logic [7:0][PIX_W-1:0] q_pix,
  input  logic [THR_W-1:0]      thr_edge,
  input  logic [THR_W-1:0]      thr_inner,
  input  logic [THR_W-1:0]      thr_hev,
  input  logic [1:0]            width_sel,
  input  logic                  depth_sel,
  output logic                  out_valid,
  output logic                  flt_en,
  output logic                  hev,
  output logic                  flat_in,
  output logic                  flat_out
);
  import dbk_pkg::*;

  localparam int SCL_W  = THR_W + DEPTH_HI - 8;
  localparam int DIFF_W = PIX_W + 1;

  logic [SCL_W-1:0]  e_scl, i_scl, h_scl;
  logic [DIFF_W-1:0] flat_thr;
  logic              en_c, hev_c;
  logic              in_p_ok, in_q_ok, out_p_ok, out_q_ok;
  dbk_width_e        wmode;
  dbk_flags_t        flags_d, flags_q;
  logic              vld_d, vld_q;

  dbk_thr_scale #(
    .THR_W(THR_W), .DEPTH_LO(DEPTH_LO), .DEPTH_HI(DEPTH_HI),
    .SCL_W(SCL_W), .DIFF_W(DIFF_W)
  ) u_scale (
    .depth_sel(depth_sel), .thr_edge(thr_edge), .thr_inner(thr_inner),
    .thr_hev(thr_hev), .e_scl(e_scl), .i_scl(i_scl), .h_scl(h_scl),
    .flat_thr(flat_thr)
  );

  dbk_mask_eval #(.PIX_W(PIX_W), .SCL_W(SCL_W), .DIFF_W(DIFF_W)) u_mask (
    .p_near(p_pix[3:0]), .q_near(q_pix[3:0]),
    .e_scl(e_scl), .i_scl(i_scl), .h_scl(h_scl),
    .en(en_c), .hev(hev_c)
  );

  dbk_flat_eval #(.PIX_W(PIX_W), .NUM(3), .DIFF_W(DIFF_W)) u_in_p (
    .pix(p_pix[3:1]), .anchor(p_pix[0]), .flat_thr(flat_thr), .all_flat(in_p_ok)
  );
  dbk_flat_eval #(.PIX_W(PIX_W), .NUM(3), .DIFF_W(DIFF_W)) u_in_q (
    .pix(q_pix[3:1]), .anchor(q_pix[0]), .flat_thr(flat_thr), .all_flat(in_q_ok)
  );
  dbk_flat_eval #(.PIX_W(PIX_W), .NUM(4), .DIFF_W(DIFF_W)) u_out_p (
    .pix(p_pix[7:4]), .anchor(p_pix[0]), .flat_thr(flat_thr), .all_flat(out_p_ok)
  );
  dbk_flat_eval #(.PIX_W(PIX_W), .NUM(4), .DIFF_W(DIFF_W)) u_out_q (
    .pix(q_pix[7:4]), .anchor(q_pix[0]), .flat_thr(flat_thr), .all_flat(out_q_ok)
  );

  // next-state
  always_comb begin
    wmode        = dbk_width_e'(width_sel);
    flags_d      = flags_q;
    vld_d        = in_valid;
    if (in_valid) begin
      flags_d.en   = en_c;
      flags_d.hev  = hev_c;
      flags_d.fin  = en_c && in_p_ok && in_q_ok &&
                     ((wmode == WID_8) || (wmode == WID_16));
      flags_d.fout = flags_d.fin && out_p_ok && out_q_ok && (wmode == WID_16);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      flags_q <= flags_d;
    end
  end

  assign out_valid = vld_q;
  assign flt_en    = flags_q.en;
  assign hev       = flags_q.hev;
  assign flat_in   = flags_q.fin;
  assign flat_out  = flags_q.fout;
endmodule

// File: rtl/dbk_edge_judge_chk.sv
module dbk_edge_judge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] width_sel,
  input logic       out_valid,
  input logic       flt_en,
  input logic       hev,
  input logic       flat_in,
  input logic       flat_out
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({flt_en, hev, flat_in, flat_out}));  // R8
  AST_INNER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    flat_in |-> flt_en);  // R5
  AST_OUTER_NEEDS_INNER: assert property (@(posedge clk) disable iff (!rst_n)
    flat_out |-> flat_in);  // R6
  AST_W4_NO_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (width_sel == 2'b00 || width_sel == 2'b11)) |=> (!flat_in && !flat_out));  // R7
  AST_W8_NO_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == 2'b01) |=> !flat_out);  // R7
endmodule

bind dbk_edge_judge dbk_edge_judge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
  .out_valid(out_valid), .flt_en(flt_en), .hev(hev),
  .flat_in(flat_in), .flat_out(flat_out)
);

// File: tb/dbk_edge_judge_test.sv
module dbk_edge_judge_test;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [7:0][11:0] pp, qq;
  logic [7:0]       te, ti, th;
  logic [1:0]       wsel;
  logic             dsel;
  logic             out_valid, flt_en, hev, flat_in, flat_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dbk_edge_judge uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .p_pix(pp), .q_pix(qq),
    .thr_edge(te), .thr_inner(ti), .thr_hev(th), .width_sel(wsel),
    .depth_sel(dsel), .out_valid(out_valid), .flt_en(flt_en), .hev(hev),
    .flat_in(flat_in), .flat_out(flat_out)
  );

  function automatic int ad(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // returns {en, hev, fin, fout}
  function automatic logic [3:0] model();
    int sh, es, is, hs, ft, mx, em, pv;
    logic en, hv, fi, fo;
    sh = dsel ? 4 : 2;
    es = int'(te) << sh; is = int'(ti) << sh; hs = int'(th) << sh;
    ft = 1 << sh;
    mx = 0;
    for (int k = 0; k < 3; k++) begin
      if (ad(pp[k+1], pp[k]) > mx) mx = ad(pp[k+1], pp[k]);
      if (ad(qq[k+1], qq[k]) > mx) mx = ad(qq[k+1], qq[k]);
    end
    em = 2 * ad(pp[0], qq[0]) + (ad(pp[1], qq[1]) / 2);
    en = (mx <= is) && (em <= es);
    pv = (ad(pp[1], pp[0]) > ad(qq[1], qq[0])) ? ad(pp[1], pp[0]) : ad(qq[1], qq[0]);
    hv = pv > hs;
    fi = en && (wsel == 2'b01 || wsel == 2'b10);
    for (int k = 1; k < 4; k++)
      if (ad(pp[k], pp[0]) > ft || ad(qq[k], qq[0]) > ft) fi = 1'b0;
    fo = fi && (wsel == 2'b10);
    for (int k = 4; k < 8; k++)
      if (ad(pp[k], pp[0]) > ft || ad(qq[k], qq[0]) > ft) fo = 1'b0;
    return {en, hv, fi, fo};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp_v);
    end
  endtask

  // drive on negedge, registered at next posedge, sampled on following negedge
  task automatic run_vec(input string tag);
    logic [3:0] e;
    e = model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R8 out_valid"}, out_valid, 1'b1);
    chk({tag, " R2/R3 flt_en"}, flt_en, e[3]);
    chk({tag, " R4 hev"}, hev, e[2]);
    chk({tag, " R5 flat_in"}, flat_in, e[1]);
    chk({tag, " R6 flat_out"}, flat_out, e[0]);
  endtask

  task automatic fill(input int base);
    for (int k = 0; k < 8; k++) begin
      pp[k] = 12'(base);
      qq[k] = 12'(base);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed, base, rng, lim;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; in_valid = 1'b0; fill(0);
    te = 0; ti = 0; th = 0; wsel = 0; dsel = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", out_valid, 1'b0);
    chk("R8 reset flt_en", flt_en, 1'b0);
    chk("R8 reset hev", hev, 1'b0);
    chk("R8 reset flat_in", flat_in, 1'b0);
    chk("R8 reset flat_out", flat_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: interior boundary, 12-bit scale 16
    dsel = 1; wsel = 2'b10; te = 8'd255; ti = 8'd1; th = 8'd255;
    fill(2000); pp[3] = 12'd2016; run_vec("R1 R2 d12 at limit");
    chk("R2 d12 at limit en", flt_en, 1'b1);
    pp[3] = 12'd2017; run_vec("R1 R2 d12 over limit");
    chk("R2 d12 over limit en", flt_en, 1'b0);
    // R1: 10-bit scale 4
    dsel = 0; fill(500); pp[3] = 12'd504; run_vec("R1 d10 at limit");
    chk("R1 d10 at limit en", flt_en, 1'b1);
    pp[3] = 12'd505; run_vec("R1 d10 over limit");
    chk("R1 d10 over limit en", flt_en, 1'b0);
    // R3: edge metric boundary, 10-bit E=3 -> 12
    ti = 8'd255; te = 8'd3; fill(500);
    for (int k = 0; k < 8; k++) qq[k] = 12'd505;
    run_vec("R3 metric 12");
    chk("R3 metric 12 en", flt_en, 1'b1);
    for (int k = 0; k < 8; k++) qq[k] = 12'd506;
    run_vec("R3 metric 15");
    chk("R3 metric 15 en", flt_en, 1'b0);
    // R4: variance boundary, 12-bit H=1 -> 16
    dsel = 1; te = 8'd255; th = 8'd1; fill(2000);
    pp[1] = 12'd2016; run_vec("R4 equal");
    chk("R4 equal hev", hev, 1'b0);
    pp[1] = 12'd2017; run_vec("R4 above");
    chk("R4 above hev", hev, 1'b1);
    // R5/R7: inner flatness, 12-bit thr 16
    th = 8'd255; wsel = 2'b01; fill(2000);
    qq[3] = 12'd2016; run_vec("R5 w8 flat");
    chk("R5 w8 flat_in", flat_in, 1'b1);
    qq[3] = 12'd2017; run_vec("R5 w8 not flat");
    chk("R5 w8 flat_in low", flat_in, 1'b0);
    qq[3] = 12'd2016; wsel = 2'b00; run_vec("R7 w4");
    chk("R7 w4 flat_in", flat_in, 1'b0);
    wsel = 2'b11; run_vec("R7 reserved");
    chk("R7 reserved flat_in", flat_in, 1'b0);
    // R6/R7: outer flatness
    wsel = 2'b10; fill(2000); pp[7] = 12'd2016; run_vec("R6 w16 flat");
    chk("R6 w16 flat_out", flat_out, 1'b1);
    pp[7] = 12'd2017; run_vec("R6 w16 not flat");
    chk("R6 w16 flat_out low", flat_out, 1'b0);
    pp[7] = 12'd2016; wsel = 2'b01; run_vec("R7 w8 outer");
    chk("R7 w8 flat_out", flat_out, 1'b0);
    // R6: inner fails so outer must be low
    wsel = 2'b10; ti = 8'd0; pp[1] = 12'd2001; run_vec("R6 nest");
    chk("R6 nest flat_out", flat_out, 1'b0);

    // R8: hold while in_valid low
    ti = 8'd255; fill(2000); run_vec("R8 load");
    fill(0); pp[1] = 12'd4000;
    @(negedge clk);
    chk("R8 hold out_valid", out_valid, 1'b0);
    chk("R8 hold flt_en", flt_en, 1'b1);
    chk("R8 hold hev", hev, 1'b0);
    chk("R8 hold flat_in", flat_in, 1'b1);
    chk("R8 hold flat_out", flat_out, 1'b1);

    // random vectors clustered near a base
    for (int n = 0; n < 400; n++) begin
      dsel = 1'($urandom);
      wsel = 2'($urandom);
      lim  = dsel ? 4095 : 1023;
      case ($urandom % 4)
        0: rng = 3;
        1: rng = 9;
        2: rng = 33;
        default: rng = 200;
      endcase
      base = $urandom % (lim + 1);
      for (int k = 0; k < 8; k++) begin
        int v;
        v = base + int'($urandom % (2 * rng + 1)) - rng;
        if (v < 0) v = 0;
        if (v > lim) v = lim;
        pp[k] = 12'(v);
        v = base + int'($urandom % (2 * rng + 1)) - rng;
        if (v < 0) v = 0;
        if (v > lim) v = lim;
        qq[k] = 12'(v);
      end
      te = 8'($urandom % 40);
      ti = 8'($urandom % 12);
      th = 8'($urandom % 10);
      run_vec("rand R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule